// File: doc/BRIEF.md
# Next-PC Selection Unit

This block holds the program counter of a single-cycle 32-bit core and works out where the next instruction comes from. Every cycle it forms three candidates:

- the sequential address, which is the current PC plus four;
- the PC-relative branch target;
- the pseudo-direct jump target.

A two-bit select chooses among those candidates and a register value, which serves as the target of a register-indirect jump. The chosen address is written into the PC on the next rising clock edge.

The surrounding core supplies four inputs:

- the instruction word currently being executed;
- a single branch-taken flag, already qualified by the branch decode and the ALU zero result;
- the jump-type select;
- the value read from the first register port.

The block returns the current PC, which drives instruction fetch. It also returns PC plus four, which the core uses as the return address for link writes.

Top module: `npc_unit`

## Requirements
- R1: A synchronous active-high reset loads the PC with 0x00000000, so the PC reads zero on the first cycle after reset.
- R2: With select 00 and the branch-taken flag low, the PC advances by four on each clock edge.
- R3: With select 00 and the branch-taken flag high, the next PC is the current PC plus four plus the sign-extended instruction bits 15:0 multiplied by four.
- R4: With select 01, the next PC keeps bits 31:28 of the current PC (not of PC plus four), takes instruction bits 25:0 in bits 27:2, and has bits 1:0 at zero.
- R5: With select 10, the next PC is the register input value, unchanged.
- R6: Select 11 is reserved and behaves as a sequential step, with the branch-taken flag ignored.
- R7: The PC-plus-four output always equals the current PC plus four, modulo 2^32, so 0xFFFFFFFC yields 0.
- R8: The branch-taken flag has no effect when the select is 01 or 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| instr | input | 32 | Current instruction word (offset in 15:0, jump index in 25:0) |
| br_taken | input | 1 | Branch condition already combined with ALU zero |
| pc_sel | input | 2 | Next-PC select: 00 sequential/branch, 01 jump, 10 register, 11 sequential |
| reg_a | input | 32 | First register read value, target for register jumps |
| pc | output | 32 | Current program counter |
| pc_plus4 | output | 32 | Current PC plus four, for link writes |

## Verification
The bench builds the block with its default 32-bit address, 16-bit offset and 26-bit jump-index widths. These are the only widths at which the 4-bit region field and the 256 MB boundaries exist as specified.

Register jumps are used to place the PC at chosen addresses, so that the other checks can start from known points:
- an address just below a region boundary, where PC plus four would carry into bit 28 and a jump must still keep the old upper bits;
- the top of the address space, where the sequential increment wraps to zero.

Offsets are swept across both signs, including the extreme values 0x7FFF and 0x8000. Each sweep point is tried both taken and not taken.

// File: rtl/npc_pkg.sv
package npc_pkg;
  typedef enum logic [1:0] {
    NPC_SEQ  = 2'b00,
    NPC_JUMP = 2'b01,
    NPC_REG  = 2'b10,
    NPC_RSVD = 2'b11
  } npc_sel_e;
endpackage

// File: rtl/npc_seq_adder.sv
// Sequential increment and PC-relative branch target.
module npc_seq_adder #(
  parameter int AW = 32,
  parameter int OW = 16
) (
  input  logic [AW-1:0] pc_i,
  input  logic [OW-1:0] offs_i,
  output logic [AW-1:0] inc_o,
  output logic [AW-1:0] btgt_o
);
  localparam int EXT_W = AW - OW - 2;

  logic [AW-1:0] offs_ext;

  always_comb begin
    offs_ext = {{EXT_W{offs_i[OW-1]}}, offs_i, 2'b00};
    inc_o    = pc_i + AW'(4);
    btgt_o   = inc_o + offs_ext;
  end
endmodule

// File: rtl/npc_jump_form.sv
// Pseudo-direct target: region bits of the current PC, word index, zero byte bits.
module npc_jump_form #(
  parameter int AW = 32,
  parameter int JW = 26
) (
  input  logic [AW-1:0] pc_i,
  input  logic [JW-1:0] jidx_i,
  output logic [AW-1:0] jtgt_o
);
  localparam int RW = AW - JW - 2;

  assign jtgt_o = {pc_i[AW-1 -: RW], jidx_i, 2'b00};
endmodule

// File: rtl/npc_select.sv
// Next-PC multiplexer with a 2-bit select.
module npc_select
  import npc_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [1:0]    sel_i,
  input  logic          taken_i,
  input  logic [AW-1:0] inc_i,
  input  logic [AW-1:0] btgt_i,
  input  logic [AW-1:0] jtgt_i,
  input  logic [AW-1:0] rtgt_i,
  output logic [AW-1:0] next_o
);
  npc_sel_e sel;

  always_comb begin
    sel = npc_sel_e'(sel_i);
    unique case (sel)
      NPC_SEQ:  next_o = taken_i ? btgt_i : inc_i;
      NPC_JUMP: next_o = jtgt_i;
      NPC_REG:  next_o = rtgt_i;
      default:  next_o = inc_i;
    endcase
  end
endmodule

// File: rtl/npc_unit.sv
// Program counter register and next-address selection.
module npc_unit #(
  parameter int AW = 32,
  parameter int IW = 32,
  parameter int OW = 16,
  parameter int JW = 26,
  parameter logic [AW-1:0] RST_PC = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [IW-1:0] instr,
  input  logic          br_taken,
  input  logic [1:0]    pc_sel,
  input  logic [AW-1:0] reg_a,
  output logic [AW-1:0] pc,
  output logic [AW-1:0] pc_plus4
);
  logic [AW-1:0] pc_q;
  logic [AW-1:0] inc;
  logic [AW-1:0] btgt;
  logic [AW-1:0] jtgt;
  logic [AW-1:0] next_pc;

  npc_seq_adder #(.AW(AW), .OW(OW)) seq_i (
    .pc_i   (pc_q),
    .offs_i (instr[OW-1:0]),
    .inc_o  (inc),
    .btgt_o (btgt)
  );

  npc_jump_form #(.AW(AW), .JW(JW)) jmp_i (
    .pc_i   (pc_q),
    .jidx_i (instr[JW-1:0]),
    .jtgt_o (jtgt)
  );

  npc_select #(.AW(AW)) sel_i (
    .sel_i   (pc_sel),
    .taken_i (br_taken),
    .inc_i   (inc),
    .btgt_i  (btgt),
    .jtgt_i  (jtgt),
    .rtgt_i  (reg_a),
    .next_o  (next_pc)
  );

  always_ff @(posedge clk) begin
    if (rst) pc_q <= RST_PC;
    else     pc_q <= next_pc;
  end

  assign pc       = pc_q;
  assign pc_plus4 = inc;
endmodule

// File: rtl/npc_unit_chk.sv
module npc_unit_chk (
  input logic        clk,
  input logic        rst,
  input logic [31:0] instr,
  input logic        br_taken,
  input logic [1:0]  pc_sel,
  input logic [31:0] reg_a,
  input logic [31:0] pc
);
  assert_reset_zero_R1: assert property (@(posedge clk)
    rst |=> pc == 32'h0);

  assert_seq_step_R2: assert property (@(posedge clk) disable iff (rst)
    (pc_sel == 2'b00 && !br_taken) |=> pc == $past(pc) + 32'd4);

  assert_branch_tgt_R3: assert property (@(posedge clk) disable iff (rst)
    (pc_sel == 2'b00 && br_taken) |=>
      pc == $past(pc) + 32'd4 + {{14{$past(instr[15])}}, $past(instr[15:0]), 2'b00});

  assert_jump_region_R4: assert property (@(posedge clk) disable iff (rst)
    (pc_sel == 2'b01) |=>
      (pc[31:28] == $past(pc[31:28]) && pc[27:2] == $past(instr[25:0]) && pc[1:0] == 2'b00));

  assert_reg_jump_R5: assert property (@(posedge clk) disable iff (rst)
    (pc_sel == 2'b10) |=> pc == $past(reg_a));

  assert_rsvd_seq_R6: assert property (@(posedge clk) disable iff (rst)
    (pc_sel == 2'b11) |=> pc == $past(pc) + 32'd4);
endmodule

bind npc_unit npc_unit_chk chk_i (
  .clk      (clk),
  .rst      (rst),
  .instr    (instr),
  .br_taken (br_taken),
  .pc_sel   (pc_sel),
  .reg_a    (reg_a),
  .pc       (pc)
);

// File: tb/npc_unit_tb_top.sv
module npc_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] instr = '0;
  logic        br_taken = 1'b0;
  logic [1:0]  pc_sel = 2'b00;
  logic [31:0] reg_a = '0;
  logic [31:0] pc;
  logic [31:0] pc_plus4;

  int checks = 0;
  int errors = 0;
  logic [31:0] exp_pc = '0;
  bit done = 0;

  always #10 clk = ~clk;

  npc_unit dut_i (
    .clk(clk), .rst(rst), .instr(instr), .br_taken(br_taken),
    .pc_sel(pc_sel), .reg_a(reg_a), .pc(pc), .pc_plus4(pc_plus4)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  // Called at a negedge: drive, compute the expected next PC, check at the next negedge.
  task automatic step(input string tag, input logic [1:0] s, input logic t,
                      input logic [31:0] ins, input logic [31:0] ra);
    logic [31:0] nxt;
    case (s)
      2'b00:   nxt = t ? exp_pc + 32'd4 + 32'($signed(ins[15:0]) * 4) : exp_pc + 32'd4;
      2'b01:   nxt = (exp_pc & 32'hF000_0000) | ((ins & 32'h03FF_FFFF) * 4);
      2'b10:   nxt = ra;
      default: nxt = exp_pc + 32'd4;
    endcase
    pc_sel = s; br_taken = t; instr = ins; reg_a = ra;
    @(negedge clk);
    exp_pc = nxt;
    chk(tag, pc, exp_pc);
    chk("R7 pc_plus4", pc_plus4, exp_pc + 32'd4);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    rst = 1'b0;
    exp_pc = 32'h0;
    chk("R1 reset pc", pc, 32'h0);
    chk("R7 pc_plus4 after reset", pc_plus4, 32'h4);

    for (int i = 0; i < 20; i++) step("R2 sequential", 2'b00, 1'b0, 32'h0000_FFFF, 32'hDEAD_BEEF);

    step("R5 jr setup", 2'b10, 1'b0, 32'h0, 32'h0040_0000);
    for (int i = 0; i < 24; i++) begin
      logic [15:0] off;
      if (i == 0)      off = 16'h7FFF;
      else if (i == 1) off = 16'h8000;
      else if (i == 2) off = 16'hFFFF;
      else if (i == 3) off = 16'h0000;
      else off = (i % 2 == 1) ? 16'(-(i * 37)) : 16'(i * 411);
      step("R3 branch taken", 2'b00, 1'b1, {16'hA5A5, off}, 32'h0);
      step("R2 branch not taken", 2'b00, 1'b0, {16'h5A5A, off}, 32'h0);
    end

    step("R6 reserved select", 2'b11, 1'b1, 32'h0000_7FFF, 32'h1234_5678);
    step("R6 reserved select", 2'b11, 1'b0, 32'h0000_8000, 32'h0);

    // Jump just below a region boundary: upper bits come from the current PC.
    step("R5 jr to boundary", 2'b10, 1'b0, 32'h0, 32'h0FFF_FFFC);
    step("R4 R8 jump keeps region", 2'b01, 1'b1, 32'hFFFF_FFFF, 32'h0);
    step("R5 jr to boundary", 2'b10, 1'b0, 32'h0, 32'h1FFF_FFFC);
    step("R2 cross region", 2'b00, 1'b0, 32'h0, 32'h0);
    step("R4 jump in new region", 2'b01, 1'b0, 32'h0000_0010, 32'h0);
    for (int i = 0; i < 16; i++)
      step("R4 R8 jump sweep", 2'b01, i[0], 32'(i * 32'h0123_4567), 32'hFFFF_0000);

    for (int i = 0; i < 16; i++)
      step("R5 R8 jr sweep", 2'b10, i[0], 32'h0000_8004, 32'(i * 32'h1357_9BDC) & 32'hFFFF_FFFC);

    step("R5 jr to top", 2'b10, 1'b0, 32'h0, 32'hFFFF_FFFC);
    step("R7 R2 wrap to zero", 2'b00, 1'b0, 32'h0, 32'h0);

    step("R2 before reset", 2'b00, 1'b0, 32'h0, 32'h0);
    rst = 1'b1; pc_sel = 2'b10; reg_a = 32'hCAFE_0000;
    @(negedge clk);
    rst = 1'b0; exp_pc = 32'h0;
    chk("R1 mid-run reset", pc, 32'h0);
    chk("R7 pc_plus4 after reset", pc_plus4, 32'h4);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule